// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides, cycle by cycle, whether a 32-bit CPU must leave its normal instruction flow. It takes a latched nonmaskable interrupt, a debug-port interrupt, a 4-bit encoded external interrupt level, a synchronous general exception strobe with its code, and a return-from-exception strobe. The CPU also supplies its current PC and SR. When an event is accepted, the block copies PC and SR into its saved registers and records the event code. On the following cycle it presents a redirect with the branch target and the new SR, which has the block bit (SR bit 28) set.

The block bit prevents nesting. An interrupt that arrives while the bit is set stays pending until software clears the bit, and is taken then. A general exception that arrives while the bit is set is treated as a fatal double fault. The block asks the CPU to reinitialise itself and branches to the restart address, leaving its own saved registers as they were. A return strobe restores PC and SR from the saved registers.

Requests are sampled on the rising clock edge. All outputs are registered, so a redirect is visible for exactly the one cycle after the edge that accepted it. The CPU loads `next_sr_o` at the end of that cycle.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is active and after release, `redirect_o` and `reinit_o` are 0, and `saved_pc_o`, `saved_sr_o` and `evt_code_o` are 0.
- R2: An external level n from 0 to 14, accepted alone, records event code 0x200 + 0x20*n. For example, 0 gives 0x200 and 14 gives 0x3C0. Level 15 means no external request.
- R3: An accepted nonmaskable interrupt records code 0x1C0. An accepted debug-port interrupt records code 0x5E0. A rising edge on `nmi_i` is remembered until it is accepted.
- R4: When several interrupts are requested together, the nonmaskable interrupt wins over the debug-port interrupt, and the debug-port interrupt wins over the external level. Requests that lose remain requested.
- R5: On every accepted interrupt or general exception, `saved_pc_o` takes `cur_pc_i` and `saved_sr_o` takes `cur_sr_i`, both sampled at the accepting edge.
- R6: An accepted interrupt redirects to `VEC_BASE + 0x600`, with `next_sr_o` equal to `cur_sr_i` with bit 28 set.
- R7: While `cur_sr_i[28]` is 1, no interrupt is accepted. A pending interrupt is taken on the first cycle the bit reads 0.
- R8: A general exception with `cur_sr_i[28]` = 1 pulses `reinit_o` together with `redirect_o`, with `next_pc_o` = 0xA0000000 and `next_sr_o` = 0x700000F0. The saved PC, saved SR and event code stay unchanged.
- R9: A return strobe redirects to `saved_pc_o` with `next_sr_o` = `saved_sr_o`, and leaves the saved registers unchanged. It has priority over any interrupt in the same cycle.
- R10: The event code register never holds 0x120, 0x140 or 0x3E0.
- R11: No interrupt is accepted in the cycle in which `redirect_o` is 1. The request is held until the cycle after.
- R12: With no request present, `redirect_o` stays 0 and the saved registers and event code hold their values.
- R13: A general exception with `cur_sr_i[28]` = 0 redirects to `VEC_BASE + 0x100`, with bit 28 set in `next_sr_o`, and records `gexc_code_i` as the event code. It has priority over interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Nonmaskable interrupt, rising-edge sensitive |
| dbg_irq_i | input | 1 | Debug-port interrupt, level |
| ext_lvl_i | input | 4 | Encoded external interrupt level, 15 = none |
| gexc_i | input | 1 | General exception strobe |
| gexc_code_i | input | 12 | Code of the general exception |
| rte_i | input | 1 | Return-from-exception strobe |
| cur_pc_i | input | 32 | Current PC of the CPU |
| cur_sr_i | input | 32 | Current SR of the CPU, bit 28 is the block bit |
| redirect_o | output | 1 | Next PC and SR are valid this cycle |
| reinit_o | output | 1 | CPU reinitialise request |
| next_pc_o | output | 32 | Branch target |
| next_sr_o | output | 32 | SR value to load |
| saved_pc_o | output | 32 | Saved PC register |
| saved_sr_o | output | 32 | Saved SR register |
| evt_code_o | output | 12 | Event code register |

## Verification
The properties assume the CPU's behaviour around a redirect. Neither `gexc_i` nor `rte_i` is asserted in the cycle `redirect_o` is high, and the two strobes are never asserted together. `gexc_code_i` never carries a reserved code. The stimulus keeps to these rules because the bench tracks its own copy of the redirect state: it raises either strobe only outside a redirect cycle and picks one strobe at most. Random exception codes are drawn as multiples of 0x20 and moved off the three reserved values. Interrupt inputs and the block bit are left free, so that holdoff and pending behaviour are exercised against random levels.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_NMI = 12'h1C0;
  localparam logic [CODE_W-1:0] CODE_DBG = 12'h5E0;
  localparam logic [CODE_W-1:0] CODE_EXT_BASE = 12'h200;
  localparam int EXT_STEP_SH = 5;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RTE,
    ACT_GEXC,
    ACT_REINIT,
    ACT_IRQ
  } act_e;
endpackage

// File: rtl/exc_nmi_pend.sv
module exc_nmi_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic req_o
);
  logic nmi_q, pend_q;

  assign req_o = pend_q | (nmi_i & ~nmi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= req_o & ~take_i;
    end
  end
endmodule

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
  import exc_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              nmi_req_i,
  input  logic              dbg_req_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic              valid_o,
  output logic              sel_nmi_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  logic ext_req;
  logic [CODE_W-1:0] ext_code;

  assign ext_req  = (lvl_i != LVL_NONE);
  assign ext_code = CODE_EXT_BASE + (CODE_W'(lvl_i) << EXT_STEP_SH);

  always_comb begin
    valid_o   = nmi_req_i | dbg_req_i | ext_req;
    sel_nmi_o = nmi_req_i;
    if (nmi_req_i)      code_o = CODE_NMI;
    else if (dbg_req_i) code_o = CODE_DBG;
    else                code_o = ext_code;
  end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_o  <= '0;
      ssr_o  <= '0;
      code_o <= '0;
    end else if (load_i) begin
      spc_o  <= pc_i;
      ssr_o  <= sr_i;
      code_o <= code_i;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          LVL_W     = 4,
  parameter int          BL_BIT    = 28,
  parameter logic [31:0] VEC_BASE  = 32'h8000_0000,
  parameter logic [31:0] GEXC_OFS  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFS   = 32'h0000_0600,
  parameter logic [31:0] REINIT_PC = 32'hA000_0000,
  parameter logic [31:0] REINIT_SR = 32'h7000_00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              dbg_irq_i,
  input  logic [LVL_W-1:0]  ext_lvl_i,
  input  logic              gexc_i,
  input  logic [CODE_W-1:0] gexc_code_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   cur_sr_i,
  output logic              redirect_o,
  output logic              reinit_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   next_sr_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [XLEN-1:0]   saved_sr_o,
  output logic [CODE_W-1:0] evt_code_o
);
  localparam logic [XLEN-1:0] BL_MASK  = XLEN'(1) << BL_BIT;
  localparam logic [XLEN-1:0] GEXC_TGT = XLEN'(VEC_BASE + GEXC_OFS);
  localparam logic [XLEN-1:0] IRQ_TGT  = XLEN'(VEC_BASE + IRQ_OFS);

  logic              blk;
  logic              nmi_req, take_nmi;
  logic              irq_v, irq_nmi;
  logic [CODE_W-1:0] irq_code;
  logic              save_ld;
  logic [CODE_W-1:0] save_code;
  act_e              act;

  assign blk = cur_sr_i[BL_BIT];

  exc_nmi_pend u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (take_nmi),
    .req_o  (nmi_req)
  );

  exc_irq_arb #(.LVL_W(LVL_W)) u_arb (
    .nmi_req_i (nmi_req),
    .dbg_req_i (dbg_irq_i),
    .lvl_i     (ext_lvl_i),
    .valid_o   (irq_v),
    .sel_nmi_o (irq_nmi),
    .code_o    (irq_code)
  );

  // strobes from the instruction stream win; interrupts wait out blk and the redirect cycle
  always_comb begin
    if (rte_i)                        act = ACT_RTE;
    else if (gexc_i)                  act = blk ? ACT_REINIT : ACT_GEXC;
    else if (irq_v && !blk && !redirect_o) act = ACT_IRQ;
    else                              act = ACT_NONE;
  end

  assign take_nmi  = (act == ACT_IRQ) && irq_nmi;
  assign save_ld   = (act == ACT_GEXC) || (act == ACT_IRQ);
  assign save_code = (act == ACT_GEXC) ? gexc_code_i : irq_code;

  exc_save_bank #(.XLEN(XLEN)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (save_ld),
    .pc_i   (cur_pc_i),
    .sr_i   (cur_sr_i),
    .code_i (save_code),
    .spc_o  (saved_pc_o),
    .ssr_o  (saved_sr_o),
    .code_o (evt_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      reinit_o   <= 1'b0;
      next_pc_o  <= '0;
      next_sr_o  <= '0;
    end else begin
      redirect_o <= (act != ACT_NONE);
      reinit_o   <= (act == ACT_REINIT);
      unique case (act)
        ACT_RTE: begin
          next_pc_o <= saved_pc_o;
          next_sr_o <= saved_sr_o;
        end
        ACT_GEXC: begin
          next_pc_o <= GEXC_TGT;
          next_sr_o <= cur_sr_i | BL_MASK;
        end
        ACT_IRQ: begin
          next_pc_o <= IRQ_TGT;
          next_sr_o <= cur_sr_i | BL_MASK;
        end
        ACT_REINIT: begin
          next_pc_o <= REINIT_PC;
          next_sr_o <= REINIT_SR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int          XLEN      = 32,
  parameter int          BL_BIT    = 28,
  parameter logic [31:0] REINIT_PC = 32'hA000_0000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            gexc_i,
  input logic            rte_i,
  input logic [XLEN-1:0] cur_sr_i,
  input logic            redirect_o,
  input logic            reinit_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] next_sr_o,
  input logic [XLEN-1:0] saved_pc_o,
  input logic [XLEN-1:0] saved_sr_o,
  input logic [11:0]     evt_code_o
);
  AST_REINIT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_o |-> (redirect_o && next_pc_o == XLEN'(REINIT_PC))); // R8

  AST_REINIT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_o |-> ($stable(saved_pc_o) && $stable(saved_sr_o) && $stable(evt_code_o))); // R8

  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_code_o != 12'h120 && evt_code_o != 12'h140 && evt_code_o != 12'h3E0)); // R10

  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o); // R11

  AST_BLOCKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cur_sr_i[BL_BIT]) && !$past(gexc_i) && !$past(rte_i)) |-> !redirect_o); // R7

  AST_RTE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rte_i) |-> (redirect_o && next_pc_o == saved_pc_o && next_sr_o == saved_sr_o
                      && $stable(saved_pc_o) && $stable(saved_sr_o))); // R9

  AST_BL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !reinit_o && !$past(rte_i)) |-> next_sr_o[BL_BIT]); // R6
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .BL_BIT(BL_BIT), .REINIT_PC(REINIT_PC)) u_chk (.*);

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int BL = 28;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nmi = 1'b0, dbg = 1'b0, gexc = 1'b0, rte = 1'b0;
  logic [3:0]  lvl = 4'hF;
  logic [11:0] gcode = '0;
  logic [31:0] pc = '0, sr = '0;
  logic        redirect, reinit;
  logic [31:0] npc, nsr, spc, ssr;
  logic [11:0] evt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_spc = '0, m_ssr = '0;
  logic [11:0] m_evt = '0;
  logic        m_pend = 0, m_nmiq = 0, m_red = 0;

  always #4 clk = ~clk;

  exc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .nmi_i(nmi), .dbg_irq_i(dbg), .ext_lvl_i(lvl),
    .gexc_i(gexc), .gexc_code_i(gcode), .rte_i(rte), .cur_pc_i(pc), .cur_sr_i(sr),
    .redirect_o(redirect), .reinit_o(reinit), .next_pc_o(npc), .next_sr_o(nsr),
    .saved_pc_o(spc), .saved_sr_o(ssr), .evt_code_o(evt)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] irq_code(input logic nv, input logic d, input logic [3:0] l);
    if (nv) return 12'h1C0;
    if (d)  return 12'h5E0;
    return 12'h200 + {3'b0, l, 5'b0};
  endfunction

  // drive at negedge, expect after the next posedge, check at the following negedge
  task automatic step(input logic n, input logic d, input logic [3:0] l, input logic g,
                      input logic [11:0] gc, input logic r, input logic [31:0] p, input logic [31:0] s);
    logic nv, iv, e_red, e_rei, acc_nmi;
    logic [31:0] e_pc, e_sr;
    string tag, stag;
    nmi = n; dbg = d; lvl = l; gexc = g; gcode = gc; rte = r; pc = p; sr = s;
    nv = m_pend | (n & ~m_nmiq);
    iv = nv | d | (l != 4'hF);
    e_red = 0; e_rei = 0; e_pc = '0; e_sr = '0; acc_nmi = 0;
    tag = "R12"; stag = "R12";
    if (r) begin
      e_red = 1; e_pc = m_spc; e_sr = m_ssr; tag = "R9"; stag = "R9";
    end else if (g) begin
      if (s[BL]) begin
        e_red = 1; e_rei = 1; e_pc = 32'hA000_0000; e_sr = 32'h7000_00F0; tag = "R8"; stag = "R8";
      end else begin
        e_red = 1; e_pc = BASE + 32'h100; e_sr = s | (32'd1 << BL); tag = "R13"; stag = "R5";
        m_spc = p; m_ssr = s; m_evt = gc;
      end
    end else if (iv) begin
      if (m_red)      begin tag = "R11"; stag = "R11"; end
      else if (s[BL]) begin tag = "R7";  stag = "R7";  end
      else begin
        e_red = 1; e_pc = BASE + 32'h600; e_sr = s | (32'd1 << BL); stag = "R5";
        if (nv && (d || l != 4'hF)) tag = "R4";
        else if (nv || d)           tag = "R3";
        else                        tag = "R2";
        acc_nmi = nv;
        m_spc = p; m_ssr = s; m_evt = irq_code(nv, d, l);
      end
    end
    m_pend = nv & ~acc_nmi;
    m_nmiq = n;
    m_red  = e_red;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "redirect", {31'b0, redirect}, {31'b0, e_red});
    chk(tag, "reinit", {31'b0, reinit}, {31'b0, e_rei});
    if (e_red) begin
      chk(tag, "next_pc", npc, e_pc);
      chk(tag, "next_sr", nsr, e_sr);
    end
    chk(stag, "saved_pc", spc, m_spc);
    chk(stag, "saved_sr", ssr, m_ssr);
    chk((tag == "R2" || tag == "R3" || tag == "R4" || tag == "R13") ? tag : stag,
        "evt_code", {20'b0, evt}, {20'b0, m_evt});
    chk("R10", "reserved", {31'b0, (evt == 12'h120 || evt == 12'h140 || evt == 12'h3E0)}, 32'd0);
  endtask

  task automatic idle(input logic [31:0] s);
    step(nmi, 1'b0, 4'hF, 1'b0, 12'h0, 1'b0, pc, s);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", "redirect", {31'b0, redirect}, 32'd0);
    chk("R1", "saved_pc", spc, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "reinit", {31'b0, reinit}, 32'd0);
    chk("R1", "evt_code", {20'b0, evt}, 32'd0);

    // R2: extreme levels
    step(0, 0, 4'hE, 0, 0, 0, 32'h1000, 32'h0000_0001);
    chk("R2", "level14", {20'b0, evt}, 32'h3C0);
    idle(32'h0);
    step(0, 0, 4'h0, 0, 0, 0, 32'h1004, 32'h0000_0002);
    chk("R2", "level0", {20'b0, evt}, 32'h200);
    idle(32'h0);
    step(0, 0, 4'hF, 0, 0, 0, 32'h1008, 32'h0);  // R12 no request
    // R4 priority then remaining requests
    step(1, 1, 4'h3, 0, 0, 0, 32'h2000, 32'h0);
    idle(32'h0);
    step(1, 1, 4'h3, 0, 0, 0, 32'h2004, 32'h0);
    idle(32'h0);
    step(0, 0, 4'h3, 0, 0, 0, 32'h2008, 32'h0);
    idle(32'h0);
    // R7 block bit holds requests; nmi edge stays pending
    step(0, 0, 4'h5, 0, 0, 0, 32'h3000, 32'h1000_0000);
    step(1, 0, 4'h5, 0, 0, 0, 32'h3004, 32'h1000_0000);
    step(0, 0, 4'hF, 0, 0, 0, 32'h3008, 32'h1000_0000);
    step(0, 0, 4'hF, 0, 0, 0, 32'h300C, 32'h0000_0000);
    idle(32'h0);
    // R11 holdoff
    step(0, 0, 4'h2, 0, 0, 0, 32'h4000, 32'h0);
    step(0, 0, 4'h2, 0, 0, 0, 32'h4004, 32'h0);
    idle(32'h1000_0000);
    // R13, R8, R9
    step(0, 0, 4'h4, 1, 12'h0E0, 0, 32'h5000, 32'h0000_00F0);
    idle(32'h1000_0000);
    step(0, 0, 4'hF, 1, 12'h1A0, 0, 32'h5004, 32'h1000_0000);
    idle(32'h1000_0000);
    step(0, 0, 4'h1, 0, 0, 1, 32'h5008, 32'h1000_0000);
    idle(32'h1000_0000);

    for (int i = 0; i < 3000; i++) begin
      logic n, d, g, r;
      logic [3:0] l;
      logic [11:0] gc;
      logic [31:0] s;
      n = ($urandom_range(0, 7) == 0) ? ~nmi : nmi;
      d = ($urandom_range(0, 5) == 0);
      l = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom_range(0, 15));
      s = $urandom;
      s[BL] = ($urandom_range(0, 2) == 0);
      g = 0; r = 0;
      if (!m_red) begin
        case ($urandom_range(0, 7))
          0: g = 1;
          1: r = 1;
          default: ;
        endcase
      end
      gc = {7'($urandom_range(2, 127)), 5'b0};
      while (gc == 12'h120 || gc == 12'h140 || gc == 12'h3E0) gc = gc + 12'h20;
      step(n, d, l, g, gc, r, $urandom, s);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule